// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical address, the way a 16-bit processor's bus interface does when it runs without protection or paging. It keeps four segment registers (code, data, extra, stack) and an instruction pointer. Each cycle the requester presents an access kind and an offset. The block picks the segment that the kind implies, applies an optional segment override where one is allowed, and drives the physical address combinationally from the current register state.

Three kinds of update change that state. A segment register can be written. The instruction pointer can be stepped by the length of the instruction just fetched. A far jump loads the code segment and the instruction pointer together. All updates are synchronous, so the new values are used for addresses from the following cycle.

Top module: `seg_addr_gen`

## Requirements
- R1: `physAddr` equals (selected segment × 16) + offset. Any carry out of bit 19 is discarded, so addresses wrap at 1 MB.
- R2: Access kind 3'd0 (fetch) always uses CS with the instruction pointer. `accOffset`, `ovrEn` and `ovrSel` have no effect on a fetch address.
- R3: Access kind 3'd1 (plain data), and kinds 3'd5 to 3'd7, use DS. When `ovrEn` is high, the segment named by `ovrSel` replaces DS (00=ES, 01=CS, 10=SS, 11=DS).
- R4: Access kind 3'd3 (string source) uses DS, and the override replaces it as in R3. Access kind 3'd4 (string destination) always uses ES, whatever the override inputs hold.
- R5: Access kind 3'd2 (stack) always uses SS, whatever the override inputs hold.
- R6: Synchronous reset sets CS to 16'hFFFF and sets DS, ES, SS and IP to zero. After reset the fetch address is 20'hFFFF0.
- R7: When `segWrEn` is high, the register selected by `segWrSel` (same code as R3) takes `segWrData` at the clock edge. The new value is used from the next cycle.
- R8: When `ipAdvEn` is high and there is no far jump, IP increases by `ipAdvLen` modulo 2^16, and CS does not change.
- R9: When `farJmp` is high, CS takes `farCs` and IP takes `farIp` at the clock edge. The far jump wins over a CS write and over an IP advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| accKind | input | 3 | Access kind (see R2 to R5) |
| accOffset | input | 16 | Offset for non-fetch accesses |
| ovrEn | input | 1 | Segment override enable |
| ovrSel | input | 2 | Override segment code |
| segWrEn | input | 1 | Segment register write strobe |
| segWrSel | input | 2 | Segment register to write |
| segWrData | input | 16 | Value to write |
| ipAdvEn | input | 1 | Step the instruction pointer |
| ipAdvLen | input | 4 | Instruction length in bytes |
| farJmp | input | 1 | Far jump/call strobe |
| farCs | input | 16 | New code segment |
| farIp | input | 16 | New instruction pointer |
| physAddr | output | 20 | Physical address for the current access |
| curIp | output | 16 | Current instruction pointer |

## Verification
Random sequences mix every access kind with random offsets, override settings, segment writes, IP steps and far jumps. A wrong segment choice for any kind therefore shows up as an address mismatch against a register model kept in the bench. Directed cases cover the following:
- Segment and offset both at all ones, which separates a 1 MB wrap from a 21-bit sum.
- An IP step that crosses 16'hFFFF, which separates a 16-bit wrap from a carry into CS.
- Each override code applied to each kind, which separates overridable kinds from fixed ones.
- A far jump issued in the same cycle as a CS write and an IP step, which exposes the priority order.

// File: rtl/segaddr_pkg.sv
package segaddr_pkg;
  localparam int NSEG = 4;

  typedef enum logic [1:0] {
    SEG_ES = 2'b00,
    SEG_CS = 2'b01,
    SEG_SS = 2'b10,
    SEG_DS = 2'b11
  } segCode_e;

  typedef enum logic [2:0] {
    ACC_FETCH = 3'd0,
    ACC_DATA  = 3'd1,
    ACC_STACK = 3'd2,
    ACC_SRC   = 3'd3,
    ACC_DST   = 3'd4
  } accKind_e;

  typedef struct packed {
    logic [NSEG-1:0] segLoad;    // one-hot write enable per segment code
    logic            csFromJump; // CS takes far target
    logic            ipLoad;     // IP takes far target
    logic            ipStep;     // IP advances by length
    logic [1:0]      addrSeg;    // segment code used for address
    logic            useIp;      // offset comes from IP
  } strobes_t;
endpackage

// File: rtl/seg_addr_ctrl.sv
module seg_addr_ctrl
  import segaddr_pkg::*;
(
  input  logic [2:0] accKind,
  input  logic       ovrEn,
  input  logic [1:0] ovrSel,
  input  logic       segWrEn,
  input  logic [1:0] segWrSel,
  input  logic       ipAdvEn,
  input  logic       farJmp,
  output strobes_t   strobes
);
  logic [1:0] dataSeg;

  always_comb begin
    dataSeg = ovrEn ? ovrSel : SEG_DS;
    strobes = '0;
    strobes.segLoad    = segWrEn ? (NSEG'(1) << segWrSel) : '0;
    strobes.csFromJump = farJmp;
    strobes.ipLoad     = farJmp;
    strobes.ipStep     = ipAdvEn && !farJmp;
    case (accKind)
      ACC_FETCH: begin
        strobes.addrSeg = SEG_CS;
        strobes.useIp   = 1'b1;
      end
      ACC_STACK: strobes.addrSeg = SEG_SS;
      ACC_DST:   strobes.addrSeg = SEG_ES;
      ACC_SRC:   strobes.addrSeg = dataSeg;
      default:   strobes.addrSeg = dataSeg;
    endcase
  end
endmodule

// File: rtl/seg_addr_dp.sv
module seg_addr_dp
  import segaddr_pkg::*;
#(
  parameter int SEG_W    = 16,
  parameter int OFF_W    = 16,
  parameter int SHIFT_W  = 4,
  parameter int LEN_W    = 4,
  parameter logic [SEG_W-1:0] RESET_CS = '1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  strobes_t                 strobes,
  input  logic [OFF_W-1:0]         accOffset,
  input  logic [SEG_W-1:0]         segWrData,
  input  logic [LEN_W-1:0]         ipAdvLen,
  input  logic [SEG_W-1:0]         farCs,
  input  logic [OFF_W-1:0]         farIp,
  output logic [SEG_W+SHIFT_W-1:0] physAddr,
  output logic [OFF_W-1:0]         curIp
);
  localparam int PHYS_W = SEG_W + SHIFT_W;

  logic [SEG_W-1:0] segQ [NSEG];
  logic [OFF_W-1:0] ipQ;

  for (genvar g = 0; g < NSEG; g++) begin : gSeg
    localparam logic [SEG_W-1:0] RV = (g == int'(SEG_CS)) ? RESET_CS : '0;
    if (g == int'(SEG_CS)) begin : gCode
      always_ff @(posedge clk) begin
        if (rst)                     segQ[g] <= RV;
        else if (strobes.csFromJump) segQ[g] <= farCs;
        else if (strobes.segLoad[g]) segQ[g] <= segWrData;
      end
    end else begin : gOther
      always_ff @(posedge clk) begin
        if (rst)                     segQ[g] <= RV;
        else if (strobes.segLoad[g]) segQ[g] <= segWrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 ipQ <= '0;
    else if (strobes.ipLoad) ipQ <= farIp;
    else if (strobes.ipStep) ipQ <= ipQ + OFF_W'(ipAdvLen);
  end

  logic [SEG_W-1:0] segVal;
  logic [OFF_W-1:0] offVal;

  always_comb begin
    segVal   = segQ[strobes.addrSeg];
    offVal   = strobes.useIp ? ipQ : accOffset;
    physAddr = {segVal, {SHIFT_W{1'b0}}} + PHYS_W'(offVal);
  end

  assign curIp = ipQ;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import segaddr_pkg::*;
#(
  parameter int SEG_W    = 16,
  parameter int OFF_W    = 16,
  parameter int SHIFT_W  = 4,
  parameter int LEN_W    = 4,
  parameter logic [SEG_W-1:0] RESET_CS = '1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [2:0]               accKind,
  input  logic [OFF_W-1:0]         accOffset,
  input  logic                     ovrEn,
  input  logic [1:0]               ovrSel,
  input  logic                     segWrEn,
  input  logic [1:0]               segWrSel,
  input  logic [SEG_W-1:0]         segWrData,
  input  logic                     ipAdvEn,
  input  logic [LEN_W-1:0]         ipAdvLen,
  input  logic                     farJmp,
  input  logic [SEG_W-1:0]         farCs,
  input  logic [OFF_W-1:0]         farIp,
  output logic [SEG_W+SHIFT_W-1:0] physAddr,
  output logic [OFF_W-1:0]         curIp
);
  strobes_t strobes;

  seg_addr_ctrl ctrl_i (
    .accKind(accKind), .ovrEn(ovrEn), .ovrSel(ovrSel),
    .segWrEn(segWrEn), .segWrSel(segWrSel),
    .ipAdvEn(ipAdvEn), .farJmp(farJmp), .strobes(strobes)
  );

  seg_addr_dp #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT_W(SHIFT_W),
    .LEN_W(LEN_W), .RESET_CS(RESET_CS)
  ) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes), .accOffset(accOffset),
    .segWrData(segWrData), .ipAdvLen(ipAdvLen), .farCs(farCs),
    .farIp(farIp), .physAddr(physAddr), .curIp(curIp)
  );
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int SEG_W   = 16,
  parameter int OFF_W   = 16,
  parameter int SHIFT_W = 4,
  parameter int LEN_W   = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic [2:0]               accKind,
  input logic [OFF_W-1:0]         accOffset,
  input logic                     segWrEn,
  input logic                     ipAdvEn,
  input logic [LEN_W-1:0]         ipAdvLen,
  input logic                     farJmp,
  input logic [SEG_W-1:0]         farCs,
  input logic [OFF_W-1:0]         farIp,
  input logic [SEG_W+SHIFT_W-1:0] physAddr,
  input logic [OFF_W-1:0]         curIp
);
  localparam int PHYS_W = SEG_W + SHIFT_W;

  // R1
  low_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    (accKind != 3'd0) |-> (physAddr[SHIFT_W-1:0] == accOffset[SHIFT_W-1:0]));

  // R2
  fetch_offset_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (accKind == 3'd0 && $past(accKind) == 3'd0 && $stable(curIp)
     && !$past(segWrEn) && !$past(farJmp)) |-> $stable(physAddr));

  // R5
  stack_fixed_seg_chk: assert property (@(posedge clk) disable iff (rst)
    (accKind == 3'd2 && $past(accKind) == 3'd2 && $stable(accOffset)
     && !$past(segWrEn) && !$past(farJmp)) |-> $stable(physAddr));

  // R6
  reset_ip_chk: assert property (@(posedge clk)
    rst |=> (curIp == '0));

  // R8
  ip_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ipAdvEn && !farJmp) |=> (curIp == OFF_W'($past(curIp) + OFF_W'($past(ipAdvLen)))));

  // R9
  far_ip_chk: assert property (@(posedge clk) disable iff (rst)
    farJmp |=> (curIp == $past(farIp)));

  // R9
  far_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (farJmp && !rst) |=> (accKind != 3'd0 ||
      physAddr == PHYS_W'({$past(farCs), {SHIFT_W{1'b0}}}) + PHYS_W'($past(farIp))));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT_W(SHIFT_W), .LEN_W(LEN_W)
) chk_i (
  .clk(clk), .rst(rst), .accKind(accKind), .accOffset(accOffset),
  .segWrEn(segWrEn), .ipAdvEn(ipAdvEn), .ipAdvLen(ipAdvLen),
  .farJmp(farJmp), .farCs(farCs), .farIp(farIp),
  .physAddr(physAddr), .curIp(curIp)
);

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  accKind = '0;
  logic [15:0] accOffset = '0;
  logic        ovrEn = 1'b0;
  logic [1:0]  ovrSel = '0;
  logic        segWrEn = 1'b0;
  logic [1:0]  segWrSel = '0;
  logic [15:0] segWrData = '0;
  logic        ipAdvEn = 1'b0;
  logic [3:0]  ipAdvLen = '0;
  logic        farJmp = 1'b0;
  logic [15:0] farCs = '0;
  logic [15:0] farIp = '0;
  logic [19:0] physAddr;
  logic [15:0] curIp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state, index = segment code 0 ES, 1 CS, 2 SS, 3 DS
  logic [15:0] mSeg [4];
  logic [15:0] mIp;

  always #2 clk = ~clk;

  seg_addr_gen dut_i (
    .clk(clk), .rst(rst), .accKind(accKind), .accOffset(accOffset),
    .ovrEn(ovrEn), .ovrSel(ovrSel), .segWrEn(segWrEn), .segWrSel(segWrSel),
    .segWrData(segWrData), .ipAdvEn(ipAdvEn), .ipAdvLen(ipAdvLen),
    .farJmp(farJmp), .farCs(farCs), .farIp(farIp),
    .physAddr(physAddr), .curIp(curIp)
  );

  function automatic logic [19:0] expAddr(input logic [2:0] k, input logic [15:0] off,
                                         input logic oe, input logic [1:0] os);
    logic [1:0]  s;
    logic [15:0] o;
    o = off;
    case (k)
      3'd0: begin s = 2'd1; o = mIp; end
      3'd2: s = 2'd2;
      3'd4: s = 2'd0;
      default: s = oe ? os : 2'd3;
    endcase
    return {mSeg[s], 4'h0} + {4'h0, o};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [2:0] k);
    case (k)
      3'd0: return "R2";
      3'd2: return "R5";
      3'd3, 3'd4: return "R4";
      default: return "R3";
    endcase
  endfunction

  // drive at negedge, check settled address, then apply model update at posedge
  task automatic step(input logic [2:0] k, input logic [15:0] off, input logic oe,
                      input logic [1:0] os, input logic we, input logic [1:0] ws,
                      input logic [15:0] wd, input logic ae, input logic [3:0] al,
                      input logic fj, input logic [15:0] fc, input logic [15:0] fi,
                      input string req);
    @(negedge clk);
    accKind = k; accOffset = off; ovrEn = oe; ovrSel = os;
    segWrEn = we; segWrSel = ws; segWrData = wd;
    ipAdvEn = ae; ipAdvLen = al; farJmp = fj; farCs = fc; farIp = fi;
    #1;
    chk(req, 32'(physAddr), 32'(expAddr(k, off, oe, os)));
    chk("R8", 32'(curIp), 32'(mIp));
    @(posedge clk);
    if (we) mSeg[ws] = wd;
    if (fj) begin mSeg[1] = fc; mIp = fi; end
    else if (ae) mIp = mIp + 16'(al);
  endtask

  task automatic idle();
    step(3'd1, 16'h0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, 1'b0, 4'd0, 1'b0, 16'h0, 16'h0, "R3");
  endtask

  initial begin
    mSeg[0] = 16'h0; mSeg[1] = 16'hFFFF; mSeg[2] = 16'h0; mSeg[3] = 16'h0; mIp = 16'h0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    accKind = 3'd0;
    #1;
    // R6 reset state
    chk("R6", 32'(physAddr), 32'h000FFFF0);
    chk("R6", 32'(curIp), 32'h0);
    accKind = 3'd1; accOffset = 16'h1234; #1;
    chk("R6", 32'(physAddr), 32'h00001234);

    // R7 load every segment, R1 wrap at 1 MB
    step(3'd1, 16'h0, 1'b0, 2'd0, 1'b1, 2'd3, 16'hFFFF, 1'b0, 4'd0, 1'b0, 16'h0, 16'h0, "R7");
    step(3'd1, 16'hFFFF, 1'b0, 2'd0, 1'b1, 2'd0, 16'h1000, 1'b0, 4'd0, 1'b0, 16'h0, 16'h0, "R1");
    chk("R1", 32'(physAddr), 32'h0000FFEF);
    step(3'd2, 16'h0010, 1'b0, 2'd0, 1'b1, 2'd2, 16'h2000, 1'b0, 4'd0, 1'b0, 16'h0, 16'h0, "R5");
    // override against every kind with distinct segment values
    for (int os = 0; os < 4; os++) begin
      for (int k = 0; k < 8; k++) begin
        step(3'(k), 16'h0ABC, 1'b1, 2'(os), 1'b0, 2'd0, 16'h0, 1'b0, 4'd0, 1'b0, 16'h0, 16'h0,
             reqOf(3'(k)));
      end
    end

    // R8 IP wrap, CS unchanged
    step(3'd0, 16'h0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, 1'b0, 4'd0, 1'b1, 16'h0100, 16'hFFFE, "R9");
    step(3'd0, 16'h5555, 1'b1, 2'd3, 1'b0, 2'd0, 16'h0, 1'b1, 4'd5, 1'b0, 16'h0, 16'h0, "R2");
    step(3'd0, 16'h0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, 1'b0, 4'd0, 1'b0, 16'h0, 16'h0, "R8");
    chk("R8", 32'(curIp), 32'h0003);
    chk("R8", 32'(physAddr), 32'h00001003);

    // R9 priority: far jump with CS write and IP step in same cycle
    step(3'd0, 16'h0, 1'b0, 2'd0, 1'b1, 2'd1, 16'h7777, 1'b1, 4'd4, 1'b1, 16'h4321, 16'h0042, "R9");
    step(3'd0, 16'h0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, 1'b0, 4'd0, 1'b0, 16'h0, 16'h0, "R9");
    chk("R9", 32'(physAddr), 32'h00043252);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] k;
      k = 3'($urandom % 8);
      step(k, 16'($urandom), 1'($urandom), 2'($urandom),
           ($urandom % 4) == 0, 2'($urandom), 16'($urandom),
           ($urandom % 2) == 0, 4'($urandom), ($urandom % 8) == 0,
           16'($urandom), 16'($urandom), reqOf(k));
    end
    idle();

    // R6 reset again mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; accKind = 3'd0; #1;
    chk("R6", 32'(physAddr), 32'h000FFFF0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule